// File: doc/BRIEF.md
# I2C SCL Phase Generator

This block produces the serial clock of an I2C bus master. It pulls SCL low for a programmed low period. It then releases the line and waits until the line is actually seen high. After that it holds SCL released for a programmed high period. Two pairs of period counts are held at the inputs, one for standard-rate traffic and one for fast-rate traffic. A select pin chooses which pair sets each phase.

The output is an open-drain pull-down request, not a driven level. A target that holds SCL low after the master lets go stretches the high phase by exactly the time it holds the line. The real line level comes back through a two-flop synchroniser. This fixed path, together with a counter offset, makes every high phase last the programmed count plus eight cycles. A low phase lasts its count plus one cycle, measured from the first cycle the pull-down is asserted.

Two single-cycle strobes tell the byte sequencer when to act. One fires in the first cycle of each low phase, so SDA can be changed. The other fires near the middle of each high phase, so SDA can be sampled. START and STOP generation and SDA hold timing are handled by other blocks. The block has no data stream, so all pins are plain level or pulse signals with no valid/ready handshake.

Top module: `scl_phase_gen`

## Requirements
- R1: After reset, and in every cycle after a cycle with `run_en` low, `scl_pull_low` is 0 and both strobes are 0.
- R2: Each low phase keeps `scl_pull_low` at 1 for exactly `lo_eff + 1` consecutive cycles. The count starts in the first cycle the pull-down is asserted, whatever level the line shows.
- R3: If the line rises as soon as it is released, each high phase keeps `scl_pull_low` at 0 for exactly `hi_eff + 8` cycles.
- R4: With `fast_sel` = 1 the fast pair (`fs_hi_cnt`, `fs_lo_cnt`) sets the periods. With `fast_sel` = 0 the standard pair (`ss_hi_cnt`, `ss_lo_cnt`) sets them. The select is sampled when each phase begins.
- R5: `hi_eff` is the selected high count raised to at least 6. `lo_eff` is the selected low count raised to at least 8. Counts of 6/8 or more are used unchanged.
- R6: If the line is held low for k cycles after release, counted from the first released cycle, the high phase becomes `hi_eff + 8 + k` cycles long.
- R7: `drv_update_stb` is 1 for exactly one cycle per low phase: the first cycle of that low phase.
- R8: `smp_sample_stb` is 1 for exactly one cycle per high phase. With L = `hi_eff + 4` and the first released cycle taken as index 0, that cycle is at index `3 + k + L - floor(L/2)`.
- R9: After a cycle with `run_en` high while idle, the block starts with a low phase in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| run_en | input | 1 | 1 runs the clock generator; 0 releases SCL and idles |
| fast_sel | input | 1 | 1 selects the fast count pair, 0 the standard pair |
| ss_hi_cnt | input | CNT_W | Standard-rate high count |
| ss_lo_cnt | input | CNT_W | Standard-rate low count |
| fs_hi_cnt | input | CNT_W | Fast-rate high count |
| fs_lo_cnt | input | CNT_W | Fast-rate low count |
| scl_in | input | 1 | Raw level of the SCL line (asynchronous) |
| scl_pull_low | output | 1 | 1 requests the open-drain pull-down of SCL |
| drv_update_stb | output | 1 | One-cycle pulse at the start of each low phase |
| smp_sample_stb | output | 1 | One-cycle pulse near the middle of each high phase |

## Verification
The bench sweeps both select values over every high and low count from 0 to 11. It also runs one large count pair. In each run the unselected pair is set to different values, so reading the wrong pair shows up in the measured lengths. Counts below and above the minimum tell clamping apart from pass-through. Stretch lengths from 0 to 3 cycles, applied at the moment of release, separate the synchroniser-plus-wait overhead from the counted part of the high phase. The position of the sample strobe checks the same split. A mid-phase disable checks that SCL is released in the next cycle.

// File: rtl/scl_phase_gen_pkg.sv
package scl_phase_gen_pkg;
  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_LOW  = 2'd1,
    PH_WAIT = 2'd2,
    PH_HIGH = 2'd3
  } phase_t;

  function automatic int unsigned raise_to(input int unsigned v, input int unsigned floor_v);
    return (v < floor_v) ? floor_v : v;
  endfunction
endpackage

// File: rtl/scl_line_sync.sv
module scl_line_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic line_raw,
  output logic line_q
);
  logic [STAGES-1:0] chain;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain <= '1;
    else        chain <= {chain[STAGES-2:0], line_raw};
  end

  assign line_q = chain[STAGES-1];
endmodule

// File: rtl/scl_count_pick.sv
module scl_count_pick #(
  parameter int CNT_W  = 8,
  parameter int HI_MIN = 6,
  parameter int LO_MIN = 8,
  parameter int HI_ADD = 4,
  localparam int LD_W  = CNT_W + 1
) (
  input  logic             fast_sel,
  input  logic [CNT_W-1:0] ss_hi,
  input  logic [CNT_W-1:0] ss_lo,
  input  logic [CNT_W-1:0] fs_hi,
  input  logic [CNT_W-1:0] fs_lo,
  output logic [LD_W-1:0]  hi_load,
  output logic [LD_W-1:0]  lo_load
);
  logic [CNT_W-1:0] hi_sel, lo_sel;
  logic [LD_W-1:0]  hi_clamped, lo_clamped;

  assign hi_sel = fast_sel ? fs_hi : ss_hi;
  assign lo_sel = fast_sel ? fs_lo : ss_lo;

  always_comb begin
    hi_clamped = (hi_sel < CNT_W'(HI_MIN)) ? LD_W'(HI_MIN) : {1'b0, hi_sel};
    lo_clamped = (lo_sel < CNT_W'(LO_MIN)) ? LD_W'(LO_MIN) : {1'b0, lo_sel};
    hi_load    = hi_clamped + LD_W'(HI_ADD);
    lo_load    = lo_clamped;
  end
endmodule

// File: rtl/scl_phase_gen.sv
module scl_phase_gen
  import scl_phase_gen_pkg::*;
#(
  parameter int CNT_W     = 8,
  parameter int HI_MIN    = 6,
  parameter int LO_MIN    = 8,
  parameter int SYNC_DEPTH = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run_en,
  input  logic             fast_sel,
  input  logic [CNT_W-1:0] ss_hi_cnt,
  input  logic [CNT_W-1:0] ss_lo_cnt,
  input  logic [CNT_W-1:0] fs_hi_cnt,
  input  logic [CNT_W-1:0] fs_lo_cnt,
  input  logic             scl_in,
  output logic             scl_pull_low,
  output logic             drv_update_stb,
  output logic             smp_sample_stb
);
  // Fixed high overhead of 8 = SYNC_DEPTH + 1 wait cycles + (HI_ADD + 1) counted cycles
  localparam int HI_ADD = 8 - (SYNC_DEPTH + 1) - 1;
  localparam int LD_W   = CNT_W + 1;

  phase_t          ph;
  logic [LD_W-1:0] cnt, load_q;
  logic [LD_W-1:0] hi_load, lo_load;
  logic            line_hi;

  scl_line_sync #(.STAGES(SYNC_DEPTH)) u_sync (
    .clk      (clk),
    .rst_n    (rst_n),
    .line_raw (scl_in),
    .line_q   (line_hi)
  );

  scl_count_pick #(
    .CNT_W  (CNT_W),
    .HI_MIN (HI_MIN),
    .LO_MIN (LO_MIN),
    .HI_ADD (HI_ADD)
  ) u_pick (
    .fast_sel (fast_sel),
    .ss_hi    (ss_hi_cnt),
    .ss_lo    (ss_lo_cnt),
    .fs_hi    (fs_hi_cnt),
    .fs_lo    (fs_lo_cnt),
    .hi_load  (hi_load),
    .lo_load  (lo_load)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph     <= PH_IDLE;
      cnt    <= '0;
      load_q <= '0;
    end else if (!run_en) begin
      ph     <= PH_IDLE;
      cnt    <= '0;
      load_q <= '0;
    end else begin
      case (ph)
        PH_IDLE: begin
          ph     <= PH_LOW;
          cnt    <= lo_load;
          load_q <= lo_load;
        end
        PH_LOW: begin
          if (cnt == '0) ph <= PH_WAIT;
          else           cnt <= cnt - 1'b1;
        end
        PH_WAIT: begin
          if (line_hi) begin
            ph     <= PH_HIGH;
            cnt    <= hi_load;
            load_q <= hi_load;
          end
        end
        PH_HIGH: begin
          if (cnt == '0) begin
            ph     <= PH_LOW;
            cnt    <= lo_load;
            load_q <= lo_load;
          end else begin
            cnt <= cnt - 1'b1;
          end
        end
        default: ph <= PH_IDLE;
      endcase
    end
  end

  assign scl_pull_low   = (ph == PH_LOW);
  assign drv_update_stb = (ph == PH_LOW)  && (cnt == load_q);
  assign smp_sample_stb = (ph == PH_HIGH) && (cnt == (load_q >> 1));
endmodule

// File: rtl/scl_phase_gen_chk.sv
module scl_phase_gen_chk #(
  parameter int LO_MIN = 8
) (
  input logic clk,
  input logic rst_n,
  input logic run_en,
  input logic scl_pull_low,
  input logic drv_update_stb,
  input logic smp_sample_stb
);
  logic [15:0] lo_run;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            lo_run <= '0;
    else if (scl_pull_low) lo_run <= (lo_run == 16'hFFFF) ? lo_run : lo_run + 1'b1;
    else                   lo_run <= '0;
  end

  p_off_released_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !run_en |=> (!scl_pull_low && !drv_update_stb && !smp_sample_stb));

  p_low_min_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(scl_pull_low) && $past(run_en)) |-> (lo_run >= 16'(LO_MIN + 1)));

  p_update_at_fall_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(scl_pull_low) |-> drv_update_stb);

  p_update_in_low_r7: assert property (@(posedge clk) disable iff (!rst_n)
    drv_update_stb |-> scl_pull_low);

  p_sample_released_r8: assert property (@(posedge clk) disable iff (!rst_n)
    smp_sample_stb |-> !scl_pull_low);

  p_strobes_apart_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !(smp_sample_stb && drv_update_stb));
endmodule

bind scl_phase_gen scl_phase_gen_chk #(.LO_MIN(LO_MIN)) u_chk (
  .clk            (clk),
  .rst_n          (rst_n),
  .run_en         (run_en),
  .scl_pull_low   (scl_pull_low),
  .drv_update_stb (drv_update_stb),
  .smp_sample_stb (smp_sample_stb)
);

// File: tb/tb_scl_phase_gen.sv
module tb_scl_phase_gen;
  localparam int CW = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic run_en = 1'b0;
  logic fast_sel = 1'b0;
  logic [CW-1:0] ss_hi = '0, ss_lo = '0, fs_hi = '0, fs_lo = '0;
  logic stretch = 1'b0;
  logic scl_in, scl_pull_low, drv_update_stb, smp_sample_stb;

  int n_tests = 0;
  int n_fail  = 0;
  int cyc     = 0;
  bit done    = 1'b0;

  always #10 clk = ~clk;

  assign scl_in = ~scl_pull_low & ~stretch;

  scl_phase_gen #(.CNT_W(CW)) dut (
    .clk            (clk),
    .rst_n          (rst_n),
    .run_en         (run_en),
    .fast_sel       (fast_sel),
    .ss_hi_cnt      (ss_hi),
    .ss_lo_cnt      (ss_lo),
    .fs_hi_cnt      (fs_hi),
    .fs_lo_cnt      (fs_lo),
    .scl_in         (scl_in),
    .scl_pull_low   (scl_pull_low),
    .drv_update_stb (drv_update_stb),
    .smp_sample_stb (smp_sample_stb)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int clampv(input int v, input int m);
    return (v < m) ? m : v;
  endfunction

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000 && !done) begin
      done = 1'b1;
      n_tests++;
      n_fail++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  // One full period; the pair not selected differs so a wrong pick changes lengths (R4)
  task automatic run_one(input bit fs, input int h, input int l, input int k);
    int he, le, ld, nlo, nhi, nup, nsm, sidx, g;
    run_en   = 1'b0;
    fast_sel = fs;
    if (fs) begin fs_hi = CW'(h); fs_lo = CW'(l); ss_hi = CW'(h + 7); ss_lo = CW'(l + 9); end
    else    begin ss_hi = CW'(h); ss_lo = CW'(l); fs_hi = CW'(h + 7); fs_lo = CW'(l + 9); end
    repeat (2) @(negedge clk);
    run_en = 1'b1;
    @(negedge clk);
    // R9: low phase begins right after enable
    chk(scl_pull_low == 1'b1, "R9 start low", int'(scl_pull_low), 1);
    he = clampv(h, 6);
    le = clampv(l, 8);
    ld = he + 4;
    nlo = 0; nup = 0; g = 0;
    while (scl_pull_low && g < 2000) begin
      nlo++;
      if (drv_update_stb) nup++;
      if (drv_update_stb && nlo != 1) chk(1'b0, "R7 update position", nlo, 1);
      g++;
      @(negedge clk);
    end
    nhi = 0; nsm = 0; sidx = -1; g = 0;
    while (!scl_pull_low && g < 2000) begin
      stretch = (nhi < k);
      if (smp_sample_stb) begin nsm++; sidx = nhi; end
      nhi++;
      g++;
      @(negedge clk);
    end
    stretch = 1'b0;
    chk(drv_update_stb == 1'b1, "R7 update on next fall", int'(drv_update_stb), 1);
    run_en = 1'b0;
    chk(nlo == le + 1, "R2/R4/R5 low length", nlo, le + 1);
    chk(nhi == he + 8 + k, "R3/R4/R5/R6 high length", nhi, he + 8 + k);
    chk(nup == 1, "R7 update count", nup, 1);
    chk(nsm == 1, "R8 sample count", nsm, 1);
    chk(sidx == 3 + k + ld - ld / 2, "R8 sample index", sidx, 3 + k + ld - ld / 2);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    chk(scl_pull_low == 1'b0, "R1 reset pull", int'(scl_pull_low), 0);
    chk(drv_update_stb == 1'b0 && smp_sample_stb == 1'b0, "R1 reset strobes",
        int'(drv_update_stb) + int'(smp_sample_stb), 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk(scl_pull_low == 1'b0, "R1 disabled pull", int'(scl_pull_low), 0);

    for (int fs = 0; fs < 2; fs++)
      for (int h = 0; h < 12; h++)
        for (int l = 0; l < 12; l++)
          run_one(fs[0], h, l, (h + l) % 4);

    run_one(1'b1, 200, 150, 2);
    run_one(1'b0, 255, 255, 0);

    // R1: disable in the middle of a low phase releases SCL next cycle
    run_en = 1'b0; fast_sel = 1'b0; ss_hi = 8'd20; ss_lo = 8'd20;
    repeat (2) @(negedge clk);
    run_en = 1'b1;
    repeat (5) @(negedge clk);
    chk(scl_pull_low == 1'b1, "R2 mid low", int'(scl_pull_low), 1);
    run_en = 1'b0;
    @(negedge clk);
    chk(scl_pull_low == 1'b0, "R1 release after disable", int'(scl_pull_low), 0);
    chk(drv_update_stb == 1'b0 && smp_sample_stb == 1'b0, "R1 strobes after disable",
        int'(drv_update_stb) + int'(smp_sample_stb), 0);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule